// File: doc/BRIEF.md
# Fixed-OR Programmable Array Logic

This block models a small combinational array-logic device whose AND plane is programmable while its OR plane is hard-wired. There are ten dedicated logic inputs and eight output pins. Each output owns a private group of seven product terms that feed its own OR gate, so no term can serve two outputs. One more private product term per output decides whether that pin is driven. The pin carries the inverse of its sum of products.

Six of the outputs (pins 0 to 5) are routed back into the AND plane. A pin that drives can supply a helper term to the other outputs. A pin whose driver is off passes the externally applied level into the array instead, so it acts as an extra input. The path from the logic inputs to the pins is purely combinational. The only state is the fuse map, which is loaded one 32-bit row at a time through a synchronous write port. A fuse map must not close a combinational loop through the feedback lines.

Top module: `pal_fixed_or_array`

## Requirements
- R1: While `rst_n` is low, and after it rises, every fuse is cleared. With no rows written, each output is then enabled (`pin_oe` = 1) and drives 0 (`pin_out` = 0).
- R2: The AND plane sees 16 signals. Signals 0 to 9 are `pin_in[9:0]` and signals 10 to 15 are the feedback lines of pins 0 to 5. Fuse column 2s connects the true form of signal s and column 2s+1 connects its complement. A product term is the AND of every literal whose fuse bit is 1. A term with no fuse set evaluates to 1. A term that connects both forms of one signal is always 0.
- R3: Rows 8k+1 to 8k+7 belong to output k and to no other output. `pin_out[k]` is the inverse of the OR of those seven terms.
- R4: Row 8k is the enable term of output k, and `pin_oe[k]` equals that term. An enable row with no fuses set leaves the output permanently enabled.
- R5: Feedback line i (pins 0 to 5) carries `pin_out[i]` when `pin_oe[i]` is 1, and `pin_ext[i]` when it is 0.
- R6: For any loop-free fuse map, a helper term formed on one output and used by the product terms of another output settles within the same cycle. This holds for chains up to six outputs deep.
- R7: When `cfg_we` is high at a rising edge of `clk`, row `cfg_row` takes the value of `cfg_bits`. The new row affects the outputs only after that edge. Rows that are not addressed keep their value.
- R8: Once its enable term is 0, a feedback pin behaves as an extra input. The level applied on `pin_ext` then drives every product term that uses that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for fuse writes |
| rst_n | input | 1 | Asynchronous active-low reset; clears the fuse map |
| cfg_we | input | 1 | Row write strobe |
| cfg_row | input | 6 | Row index to write (8k = enable of output k, 8k+1..8k+7 = its logic terms) |
| cfg_bits | input | 32 | Fuse values for the addressed row |
| pin_in | input | 10 | Dedicated logic inputs |
| pin_ext | input | 6 | Levels applied externally to pins 0 to 5, seen by the array when those pins are not driven |
| pin_out | output | 8 | Inverted sum of products of each output |
| pin_oe | output | 8 | Driver enable of each output |

## Verification
On every cycle the assertions check four things. Rows change only on a write strobe, and they hold the written data afterwards. The feedback seen by the final evaluation agrees with the resolved pin levels. Empty rows and contradictory enable rows force their outputs to the known values. Only the bench's scenarios can show the actual logic functions under various input patterns. These include the deep helper-term chains, a disabled pin reading its external level, and the exact edge at which a row write becomes visible. The bench compares these against a fixed-point reference model.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int PAL_IN    = 10;
    localparam int PAL_OUT   = 8;
    localparam int PAL_FB    = 6;
    localparam int PAL_TERMS = 7;

    localparam int PAL_SIG          = PAL_IN + PAL_FB;
    localparam int PAL_ROW_W        = 2 * PAL_SIG;
    localparam int PAL_ROWS_PER_OUT = PAL_TERMS + 1;
    localparam int PAL_ROWS         = PAL_OUT * PAL_ROWS_PER_OUT;
    localparam int PAL_ROW_AW       = $clog2(PAL_ROWS);
    // a loop-free chain through the feedback lines is at most PAL_FB deep
    localparam int PAL_PASSES       = PAL_FB + 1;

    typedef logic [PAL_ROW_W-1:0]                fuse_row_t;
    typedef logic [PAL_ROWS-1:0][PAL_ROW_W-1:0]  fuse_map_t;
    typedef logic [PAL_SIG-1:0]                  sig_vec_t;

    // bit set at every column that connects a true literal
    function automatic fuse_row_t true_cols();
        fuse_row_t m;
        m = '0;
        for (int s = 0; s < PAL_SIG; s++) begin
            m[2*s] = 1'b1;
        end
        return m;
    endfunction

    localparam fuse_row_t PAL_TRUE_COLS = true_cols();

    // AND of every connected literal; an empty row yields 1
    function automatic logic product_term(fuse_row_t row, sig_vec_t sig);
        fuse_row_t lits;
        for (int s = 0; s < PAL_SIG; s++) begin
            lits[2*s]   = sig[s];
            lits[2*s+1] = ~sig[s];
        end
        return &(~row | lits);
    endfunction

endpackage

// File: rtl/pal_fuse_store.sv
module pal_fuse_store
    import pal_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PAL_ROW_AW-1:0] wr_row,
    input  logic [PAL_ROW_W-1:0]  wr_bits,
    output fuse_map_t             map_o
);

    typedef struct packed {
        fuse_map_t rows;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.rows[wr_row] = wr_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign map_o = st_q.rows;

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (map_o == '0)); // R1

    AST_ROW_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $past(rst_n)) |-> (map_o[$past(wr_row)] == $past(wr_bits))); // R7

    AST_ROWS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && $past(rst_n)) |-> $stable(map_o)); // R7

endmodule

// File: rtl/pal_plane.sv
module pal_plane
    import pal_pkg::*;
(
    input  fuse_map_t          map_i,
    input  logic [PAL_IN-1:0]  in_i,
    input  logic [PAL_FB-1:0]  fb_i,
    output logic [PAL_OUT-1:0] drv_o,
    output logic [PAL_OUT-1:0] en_o
);

    sig_vec_t            sig;
    logic [PAL_ROWS-1:0] term_hit;

    assign sig = {fb_i, in_i};

    always_comb begin
        for (int r = 0; r < PAL_ROWS; r++) begin
            term_hit[r] = product_term(map_i[r], sig);
        end
    end

    for (genvar k = 0; k < PAL_OUT; k++) begin : out_g
        localparam int BASE = k * PAL_ROWS_PER_OUT;
        assign en_o[k]  = term_hit[BASE];
        assign drv_o[k] = ~(|term_hit[BASE+1 +: PAL_TERMS]);
    end

endmodule

// File: rtl/pal_fixed_or_array.sv
module pal_fixed_or_array
    import pal_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [PAL_ROW_AW-1:0] cfg_row,
    input  logic [PAL_ROW_W-1:0]  cfg_bits,
    input  logic [PAL_IN-1:0]     pin_in,
    input  logic [PAL_FB-1:0]     pin_ext,
    output logic [PAL_OUT-1:0]    pin_out,
    output logic [PAL_OUT-1:0]    pin_oe
);

    fuse_map_t fuses;

    pal_fuse_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_row  (cfg_row),
        .wr_bits (cfg_bits),
        .map_o   (fuses)
    );

    // Unrolled evaluation: each pass resolves the pins of the previous one,
    // so a loop-free feedback chain settles without a structural loop.
    for (genvar p = 0; p < PAL_PASSES; p++) begin : pass_g
        logic [PAL_FB-1:0]  fb;
        logic [PAL_OUT-1:0] drv;
        logic [PAL_OUT-1:0] en;

        if (p == 0) begin : g_first
            assign fb = pin_ext;
        end else begin : g_next
            assign fb = (pass_g[p-1].en[PAL_FB-1:0] & pass_g[p-1].drv[PAL_FB-1:0])
                      | (~pass_g[p-1].en[PAL_FB-1:0] & pin_ext);
        end

        pal_plane u_plane (
            .map_i (fuses),
            .in_i  (pin_in),
            .fb_i  (fb),
            .drv_o (drv),
            .en_o  (en)
        );
    end

    logic [PAL_FB-1:0] fb_last;

    assign fb_last = pass_g[PAL_PASSES-1].fb;
    assign pin_out = pass_g[PAL_PASSES-1].drv;
    assign pin_oe  = pass_g[PAL_PASSES-1].en;

    AST_FB_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        fb_last == ((pin_oe[PAL_FB-1:0] & pin_out[PAL_FB-1:0])
                  | (~pin_oe[PAL_FB-1:0] & pin_ext))); // R6

    for (genvar k = 0; k < PAL_OUT; k++) begin : chk_g
        localparam int BASE = k * PAL_ROWS_PER_OUT;
        logic empty_logic;
        always_comb begin
            empty_logic = 1'b0;
            for (int j = 1; j <= PAL_TERMS; j++) begin
                if (fuses[BASE+j] == '0) begin
                    empty_logic = 1'b1;
                end
            end
        end

        AST_EMPTY_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (fuses[BASE] == '0) |-> pin_oe[k]); // R4

        AST_EMPTY_TERM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            empty_logic |-> !pin_out[k]); // R3

        AST_CONTRADICT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (|(fuses[BASE] & (fuses[BASE] >> 1) & PAL_TRUE_COLS)) |-> !pin_oe[k]); // R2
    end

endmodule

// File: tb/sim_pal_fixed_or_array.sv
`timescale 1ns/1ps
module sim_pal_fixed_or_array;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_row = '0;
    logic [31:0] cfg_bits = '0;
    logic [9:0]  pin_in = '0;
    logic [5:0]  pin_ext = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string cur_req = "R1";

    logic [31:0] mdl [64];

    always #2.5 clk = ~clk;

    pal_fixed_or_array u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row),
        .cfg_bits(cfg_bits), .pin_in(pin_in), .pin_ext(pin_ext),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // reference fuse map, written on the same edge as the design
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < 64; r++) mdl[r] <= '0;
        end else if (cfg_we) begin
            mdl[cfg_row] <= cfg_bits;
        end
    end

    function automatic logic term_val(logic [31:0] row, logic [15:0] sig);
        logic t = 1'b1;
        for (int c = 0; c < 32; c++) begin
            if (row[c]) begin
                if (c % 2 == 0) t = t & sig[c/2];
                else            t = t & ~sig[c/2];
            end
        end
        return t;
    endfunction

    // fixed-point iteration over the pin levels
    task automatic model_eval(input logic [9:0] in, input logic [5:0] ext,
                              output logic [7:0] eo, output logic [7:0] ee);
        logic [5:0] fb = ext;
        for (int it = 0; it < 10; it++) begin
            for (int k = 0; k < 8; k++) begin
                logic orv = 1'b0;
                ee[k] = term_val(mdl[8*k], {fb, in});
                for (int j = 1; j < 8; j++) orv = orv | term_val(mdl[8*k+j], {fb, in});
                eo[k] = ~orv;
            end
            for (int i = 0; i < 6; i++) fb[i] = ee[i] ? eo[i] : ext[i];
        end
    endtask

    task automatic check_all();
        logic [7:0] eo, ee;
        model_eval(pin_in, pin_ext, eo, ee);
        checks++;
        if (pin_out !== eo) begin
            errors++;
            $display("FAIL %s pin_out actual=%b expected=%b", cur_req, pin_out, eo);
        end
        checks++;
        if (pin_oe !== ee) begin
            errors++;
            $display("FAIL %s pin_oe actual=%b expected=%b", cur_req, pin_oe, ee);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check_all();
    endtask

    task automatic wr(input int row, input logic [31:0] bits);
        cfg_we = 1'b1; cfg_row = 6'(row); cfg_bits = bits;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic drive(input logic [9:0] in, input logic [5:0] ext);
        pin_in = in; pin_ext = ext;
        tick();
    endtask

    function automatic logic [31:0] lit(int s, bit neg);
        return 32'b1 << (2*s + int'(neg));
    endfunction

    function automatic logic [31:0] never_term();
        return lit(0, 1'b0) | lit(0, 1'b1);
    endfunction

    // random row whose feedback columns reference only lower outputs
    function automatic logic [31:0] rand_row(int row);
        logic [31:0] b = '0;
        int k = row / 8;
        for (int c = 0; c < 32; c++) begin
            if ($urandom_range(0, 9) == 0) begin
                if (c / 2 < 10 || (c / 2 - 10) < k) b[c] = 1'b1;
            end
        end
        return b;
    endfunction

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        drive(10'h3ff, 6'h3f);

        // R2 R3: out7 = ~((in0 & in1) | ~in2)
        cur_req = "R3";
        wr(57, lit(0, 1'b0) | lit(1, 1'b0));
        wr(58, lit(2, 1'b1));
        for (int r = 59; r < 64; r++) wr(r, never_term());
        cur_req = "R2";
        for (int v = 0; v < 16; v++) drive(10'(v) | 10'($urandom_range(0, 63) << 4), 6'h00);

        // R4: enable of out6 follows in9
        cur_req = "R4";
        wr(48, lit(9, 1'b0));
        drive(10'h200, 6'h00);
        drive(10'h000, 6'h00);
        drive(10'h3ff, 6'h3f);

        // R6: helper chain out0 -> out1 -> ... -> out5
        cur_req = "R6";
        wr(1, lit(0, 1'b0) | lit(1, 1'b0));
        for (int j = 2; j < 8; j++) wr(j, never_term());
        for (int k = 1; k < 6; k++) begin
            wr(8*k+1, lit(9 + k, 1'b0) | lit(k + 1, 1'b0));
            for (int j = 2; j < 8; j++) wr(8*k+j, never_term());
        end
        for (int v = 0; v < 128; v++) drive(10'(v), 6'(v));

        // R5 R8: pin 3 disabled, its external level feeds out4 and out7
        cur_req = "R8";
        wr(24, never_term());
        wr(59, lit(13, 1'b0));
        for (int v = 0; v < 32; v++) drive(10'($urandom_range(0, 1023)), 6'(v * 3));
        cur_req = "R5";
        drive(10'h3ff, 6'h08);
        drive(10'h3ff, 6'h00);

        // R7: write becomes visible only after the edge
        cur_req = "R7";
        cfg_we = 1'b1; cfg_row = 6'd57; cfg_bits = lit(9, 1'b0);
        #1 check_all();
        tick();
        cfg_we = 1'b0;
        drive(10'h200, 6'h00);
        drive(10'h000, 6'h00);

        // R2 R3 R6: random loop-free maps and inputs
        cur_req = "R3";
        for (int n = 0; n < 1500; n++) begin
            if ($urandom_range(0, 3) == 0) begin
                int row = $urandom_range(0, 63);
                cfg_we = 1'b1; cfg_row = 6'(row); cfg_bits = rand_row(row);
            end
            pin_in = 10'($urandom_range(0, 1023));
            pin_ext = 6'($urandom_range(0, 63));
            tick();
            cfg_we = 1'b0;
        end

        // R1: reset mid-run clears the map
        cur_req = "R1";
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        drive(10'h155, 6'h2a);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule